// File: doc/BRIEF.md
# Boot ROM Overlay and Remap Decoder

This block sits between a processor with a time-multiplexed address bus and a 4K on-card ROM. On every memory access it decides whether the ROM answers, or whether the system bus gets an active-low valid-address indication. The high address byte arrives first on the shared address lines together with an address strobe, and the block captures it. The low byte follows during the access phase and goes straight through to the ROM address.

After reset the ROM is overlaid over the whole lower 32K of the address space, mirrored every 4K, so the processor starts executing from address zero out of ROM. The first access with A15 high sets a sticky flag. What happens next depends on a 2-bit mode input. In boot-only mode the ROM drops out for good. In boot/remap mode it reappears in one 4K bank chosen by a half select and a bank select. In no-ROM mode the ROM never answers.

Top module: `boot_rom_decoder`

## Requirements
- R1: When `strobe_i` is high at a rising clock edge, `addr_i` is stored as address bits A15..A8. While `strobe_i` is low, the stored byte holds. Reset clears it to zero.
- R2: Reset clears the boot flag. A clock edge with `access_i` high and stored A15 = 1 sets it, and it stays set until the next reset.
- R3: In mode 01 (boot only) or mode 10 (boot/remap) with the flag clear, an access with A15 = 0 drives `rom_en_no` low and `vma_no` high. An access with A15 = 1 drives `rom_en_no` high and `vma_no` low.
- R4: In mode 01 with the flag set, every access drives `rom_en_no` high and `vma_no` low.
- R5: In mode 10 with the flag set, `rom_en_no` is low only when stored A15 equals `half_i` (1 = upper 32K) and stored A14..A12 equal `bank_i` (bank n starts at offset n*0x1000). Otherwise `vma_no` is low.
- R6: In mode 00 and mode 11 (both mean no ROM), `rom_en_no` stays high and `vma_no` is low for every access.
- R7: `rom_en_no` and `vma_no` are never low together. When `access_i` is low, both are high.
- R8: `rom_addr_o` equals {stored A11..A8, `addr_i`}.
- R9: During and straight after reset, both active-low outputs are high while no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Multiplexed address lines |
| strobe_i | input | 1 | High-byte capture strobe |
| access_i | input | 1 | Memory access in progress |
| mode_i | input | 2 | 00 no ROM, 01 boot only, 10 boot/remap, 11 no ROM |
| half_i | input | 1 | Remap half select, 1 = upper 32K |
| bank_i | input | 3 | Remap 4K bank within the half |
| rom_en_no | output | 1 | ROM enable, active low |
| vma_no | output | 1 | Bus valid address, active low |
| rom_addr_o | output | 12 | ROM address A11..A0 |

## Verification
Assertions check on every cycle that the two active-low outputs never overlap and that both are idle with no access. They also check that the high byte is captured on the strobe, that the flag sets on an access with A15 high and then stays set, that no-ROM and post-boot boot-only modes never enable the ROM, and that the remap window decodes correctly. Only the bench scenarios can show the full mode-by-mode sequence from reset. That sequence is the overlay mirrored across the lower half, the switch on the first high access, the default F000 window and non-default windows, and the address pass-through under random traffic.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_BOOT  = 2'b01,
    MODE_REMAP = 2'b10,
    MODE_RSVD  = 2'b11
  } rom_mode_e;
endpackage

// File: rtl/hi_latch.sv
module hi_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] lane_i,
  output logic [W-1:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_o <= '0;
    else if (strobe_i) hi_o <= lane_i;
  end

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> hi_o == $past(lane_i));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(hi_o));
endmodule

// File: rtl/boot_flag.sv
module boot_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  input  logic a15_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_o <= 1'b0;
    else if (access_i && a15_i)  flag_o <= 1'b1;
  end

  p_flag_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && a15_i) |=> flag_o);
  p_flag_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> flag_o);
endmodule

// File: rtl/rom_select.sv
module rom_select
  import boot_rom_pkg::*;
#(
  parameter int HI_W   = 8,
  parameter int BANK_W = 3
) (
  input  logic [HI_W-1:0]   hi_i,
  input  logic              access_i,
  input  logic              flag_i,
  input  logic [1:0]        mode_i,
  input  logic              half_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              rom_en_no,
  output logic              vma_no
);
  localparam int TOP = HI_W - 1;

  logic a15;
  logic bank_hit;
  logic rom_hit;

  assign a15      = hi_i[TOP];
  assign bank_hit = (a15 == half_i) && (hi_i[TOP-1 -: BANK_W] == bank_i);

  always_comb begin
    unique case (rom_mode_e'(mode_i))
      MODE_BOOT:  rom_hit = !flag_i && !a15;
      MODE_REMAP: rom_hit = flag_i ? bank_hit : !a15;
      default:    rom_hit = 1'b0;
    endcase
  end

  assign rom_en_no = !(access_i && rom_hit);
  assign vma_no    = !(access_i && !rom_hit);
endmodule

// File: rtl/boot_rom_decoder.sv
module boot_rom_decoder #(
  parameter int LANE_W = 8,
  parameter int ROM_AW = 12,
  localparam int HI_W   = LANE_W,
  localparam int PAGE_W = ROM_AW - LANE_W,
  localparam int BANK_W = HI_W - 1 - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANE_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic              access_i,
  input  logic [1:0]        mode_i,
  input  logic              half_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              rom_en_no,
  output logic              vma_no,
  output logic [ROM_AW-1:0] rom_addr_o
);
  logic [HI_W-1:0] hi_q;
  logic            flag_q;

  hi_latch #(.W(HI_W)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i),
    .lane_i(addr_i), .hi_o(hi_q)
  );

  boot_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .access_i(access_i),
    .a15_i(hi_q[HI_W-1]), .flag_o(flag_q)
  );

  rom_select #(.HI_W(HI_W), .BANK_W(BANK_W)) u_sel (
    .hi_i(hi_q), .access_i(access_i), .flag_i(flag_q), .mode_i(mode_i),
    .half_i(half_i), .bank_i(bank_i), .rom_en_no(rom_en_no), .vma_no(vma_no)
  );

  assign rom_addr_o = {hi_q[PAGE_W-1:0], addr_i};

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rom_en_no && !vma_no));
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_i |-> (rom_en_no && vma_no));
  p_norom_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 || mode_i == 2'b11) && access_i |-> (rom_en_no && !vma_no));
  p_bootoff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && flag_q && access_i) |-> rom_en_no);
  p_remap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && flag_q && access_i && !rom_en_no) |->
      (hi_q[HI_W-1] == half_i && hi_q[HI_W-2 -: BANK_W] == bank_i));
endmodule

// File: tb/boot_rom_decoder_bench.sv
module boot_rom_decoder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic       strobe_i = 1'b0;
  logic       access_i = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic       half_i = 1'b1;
  logic [2:0] bank_i = 3'd7;
  logic       rom_en_no, vma_no;
  logic [11:0] rom_addr_o;

  int checks = 0;
  int fails = 0;
  bit mflag = 0;

  always #2 clk_i = ~clk_i;

  boot_rom_decoder u_boot_rom_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .strobe_i(strobe_i),
    .access_i(access_i), .mode_i(mode_i), .half_i(half_i), .bank_i(bank_i),
    .rom_en_no(rom_en_no), .vma_no(vma_no), .rom_addr_o(rom_addr_o)
  );

  function automatic bit exp_rom(input logic [1:0] m, input bit f,
                                 input logic [7:0] hi, input bit hf,
                                 input logic [2:0] bk);
    case (m)
      2'b01:   return !f && !hi[7];
      2'b10:   return f ? (hi[7] == hf && hi[6:4] == bk) : !hi[7];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input bit hf, input logic [2:0] bk);
    @(negedge clk_i);
    rst_ni = 1'b0; access_i = 1'b0; strobe_i = 1'b0;
    mode_i = m; half_i = hf; bank_i = bk;
    #1 chk("R9 reset idle", {rom_en_no, vma_no}, 2'b11);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mflag = 0;
  endtask

  task automatic do_access(input logic [7:0] hi, input logic [7:0] lo, input string req);
    bit er;
    @(negedge clk_i);
    addr_i = hi; strobe_i = 1'b1; access_i = 1'b0;
    #1 chk("R7 idle", {rom_en_no, vma_no}, 2'b11);
    @(negedge clk_i);
    strobe_i = 1'b0; addr_i = lo; access_i = 1'b1;
    er = exp_rom(mode_i, mflag, hi, half_i, bank_i);
    #1;
    chk(req, {rom_en_no, vma_no}, {!er, er});
    chk("R8 rom addr", rom_addr_o, {hi[3:0], lo});
    if (hi[7]) mflag = 1;
    @(negedge clk_i);
    access_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R9/R3 boot-only overlay, mirrored lower half
    do_reset(2'b01, 1'b1, 3'd7);
    do_access(8'h00, 8'h00, "R3 boot overlay at zero");
    do_access(8'h7F, 8'hFF, "R3 overlay mirror 7FFF");
    do_access(8'h80, 8'h00, "R3 high access goes to bus");
    do_access(8'h00, 8'h10, "R4 boot-only disabled after flag");
    do_access(8'hF0, 8'h00, "R4 boot-only F000 to bus");
    // R1: latch holds when strobe low; R2 sticky across many
    do_access(8'h12, 8'h34, "R2 flag sticky");
    // R5 default window
    do_reset(2'b10, 1'b1, 3'd7);
    do_access(8'h00, 8'h00, "R3 remap overlay at zero");
    do_access(8'hF0, 8'h00, "R3 remap before flag F000 bus");
    do_access(8'hF0, 8'h01, "R5 remap window F000");
    do_access(8'hFF, 8'hFF, "R5 remap window FFFF");
    do_access(8'hE0, 8'h00, "R5 remap outside E000");
    do_access(8'h00, 8'h00, "R5 overlay gone at zero");
    // R5 lower half bank 2
    do_reset(2'b10, 1'b0, 3'd2);
    do_access(8'hA5, 8'h5A, "R2 first high access");
    do_access(8'h2C, 8'h00, "R5 window 2000 lower half");
    do_access(8'hA0, 8'h00, "R5 wrong half A000");
    do_access(8'h30, 8'h00, "R5 wrong bank 3000");
    // R6 no ROM
    do_reset(2'b00, 1'b1, 3'd7);
    do_access(8'h00, 8'h00, "R6 no rom at zero");
    do_access(8'hF0, 8'h00, "R6 no rom F000");
    do_reset(2'b11, 1'b1, 3'd7);
    do_access(8'h00, 8'h00, "R6 mode 11 at zero");
    do_access(8'hF8, 8'h00, "R6 mode 11 F800");
    // random traffic
    for (int s = 0; s < 30; s++) begin
      do_reset(2'($urandom), 1'($urandom), 3'($urandom));
      for (int k = 0; k < 20; k++) begin
        logic [7:0] h;
        h = 8'($urandom);
        if (($urandom % 4) != 0) h[7] = 1'b0;
        do_access(h, 8'($urandom), "R3 R4 R5 R6 random");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule